// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block decodes the multi-cycle write protocol of a NOR-style parallel flash and applies it to an internal byte array. Each accepted bus write carries a byte address, a 32-bit data word and an access size of 1, 2 or 4 bytes. Bits 7:0 of the data word are the command byte. A command only takes effect after a handshake of two writes, each at a fixed unlock offset. A bypass mode lets the host skip that handshake. Programming ANDs data into the array, so it can only clear bits. Erase sets a whole sector, or the whole array, back to all-ones.

The write port uses valid/ready. `wr_ready` is always high, so the block never applies back-pressure and each write is acted on at the clock edge where `wr_valid` is high. The read and status logic outside this block sees three things: the current command mode, the bypass flag, and a one-cycle pulse when an erase starts. That logic returns `erase_done_i` when its erase timer expires. A raw read port returns four array bytes at any address.

Unlock and query offsets are compared against the byte offset within the sector. That offset is shifted right by 1 for a 16-bit device and by 2 for a 32-bit device.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (read), `bypass_o` and `erase_start_o` are 0, `rd_data` is 0 and every array byte is 0xFF. `wr_ready` is always 1.
- R2: A write with command byte 0xF0 sets the mode to 0 and clears bypass from every mode except 3 (program data). Mode 3 takes 0xF0 as program data.
- R3: In mode 0, 0x98 at offset 0x55 enters mode 9 (query) and 0xAA at unlock offset A enters mode 1. Any other write stays in mode 0.
- R4: In mode 1, 0x55 at unlock offset B enters mode 2 (command ready). Any other write returns to mode 0.
- R5: In mode 2 the write must be at offset A, unless bypass is set. 0x20 sets bypass and stays in mode 2. 0x80 enters mode 4, 0x90 enters mode 8 (autoselect) and 0xA0 enters mode 3. Anything else returns to mode 0 and clears bypass.
- R6: In mode 3 a write ANDs its 1, 2 or 4 bytes (`wr_size` 0, 1, 2) into the array at ascending addresses. The least significant byte goes first when the byte order is little-endian. The next mode is 2 if bypass is set and 0 otherwise. `ro_i` high leaves the array unchanged.
- R7: Mode 4 expects 0xAA at offset A and moves to mode 5. Mode 5 expects 0x55 at offset B and moves to mode 6. In mode 4, 0x98 at offset 0x55 enters mode 9. Any other write in mode 4 or 5 returns to mode 0.
- R8: In mode 6, 0x10 at offset A fills the whole array with 0xFF. 0x30 at any address fills the sector holding that address with 0xFF. Either one enters mode 7 and pulses `erase_start_o` for one cycle. Any other write returns to mode 0. `ro_i` blocks the fill.
- R9: In mode 7, writes other than 0xF0 are ignored. `erase_done_i` ends the erase and moves to mode 2 if bypass is set, otherwise to mode 0.
- R10: In mode 8 with bypass set, 0x00 clears bypass and returns to mode 0. 0x98 at offset 0x55 enters mode 9. Any other write returns to mode 0.
- R11: In mode 9 any write returns to mode 0.
- R12: `rd_data` shows the four array bytes starting at `rd_addr`, as they stood one clock earlier, in the configured byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write present |
| wr_ready | output | 1 | Write accepted; always 1 |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data; bits 7:0 are the command byte |
| wr_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes |
| ro_i | input | 1 | Array is read-only; modes still advance |
| erase_done_i | input | 1 | Erase timer expired |
| rd_addr | input | AW | Raw read byte address |
| rd_data | output | 32 | Four array bytes, registered |
| mode_o | output | 4 | Current command mode |
| bypass_o | output | 1 | Unlock bypass active |
| erase_start_o | output | 1 | One-cycle pulse when an erase begins |

## Verification
Directed sequences cover the following cases:
- Well-formed handshakes, against ones broken at the first or second cycle.
- Commands at the correct offset and at the wrong offset.
- Bypass mode, where the address check is skipped.
- The abort byte as a command and as program data.
- Programming of 1, 2 and 4 bytes, including a write that spans a sector boundary.
- Sector erase against chip erase.
- Erase and program with the array read-only.

A long run of writes then follows. Its addresses are biased toward the unlock and query offsets and its data toward the command bytes. It finds ordering faults between modes that the directed cases miss. A behavioural model follows every write, and mode, bypass, pulse and read data are compared on every clock.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    M_READ   = 4'd0,
    M_UNLK2  = 4'd1,
    M_CMD    = 4'd2,
    M_PROG   = 4'd3,
    M_EUNLK1 = 4'd4,
    M_EUNLK2 = 4'd5,
    M_ESEL   = 4'd6,
    M_ERASE  = 4'd7,
    M_AUTO   = 4'd8,
    M_CFI    = 4'd9
  } fmode_t;

  localparam logic [7:0] CB_ABORT   = 8'hF0;
  localparam logic [7:0] CB_QUERY   = 8'h98;
  localparam logic [7:0] CB_KEY1    = 8'hAA;
  localparam logic [7:0] CB_KEY2    = 8'h55;
  localparam logic [7:0] CB_BYPASS  = 8'h20;
  localparam logic [7:0] CB_ESETUP  = 8'h80;
  localparam logic [7:0] CB_AUTOSEL = 8'h90;
  localparam logic [7:0] CB_PROG    = 8'hA0;
  localparam logic [7:0] CB_CHIP    = 8'h10;
  localparam logic [7:0] CB_SECT    = 8'h30;
  localparam logic [7:0] CB_BYPEXIT = 8'h00;
  localparam int         QUERY_OFF  = 'h55;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/flash_addr_split.sv
module flash_addr_split #(
  parameter int SECT_NUM = 4,
  parameter int DEV_W    = 1,
  parameter int AW       = 10,
  parameter int SW       = 8,
  parameter int SIW      = 2
) (
  input  logic [AW-1:0]  addr,
  output logic [SW-1:0]  word_off,
  output logic [SIW-1:0] sect_idx
);

  generate
    if (DEV_W == 4) begin : g_w32
      assign word_off = addr[SW-1:0] >> 2;
    end else if (DEV_W == 2) begin : g_w16
      assign word_off = addr[SW-1:0] >> 1;
    end else begin : g_w8
      assign word_off = addr[SW-1:0];
    end

    if (SECT_NUM > 1) begin : g_multi
      assign sect_idx = addr[AW-1:SW];
    end else begin : g_single
      assign sect_idx = '0;
    end
  endgenerate

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] cmd,
  input  logic       at_a,
  input  logic       at_b,
  input  logic       at_query,
  input  logic       erase_done,
  output fmode_t     mode,
  output logic       bypass,
  output logic       prog_en,
  output logic       chip_erase,
  output logic       sect_erase,
  output logic       erase_start
);

  fmode_t nxt;
  logic   nbyp;
  logic   abort;

  always_comb begin
    nxt        = mode;
    nbyp       = bypass;
    prog_en    = 1'b0;
    chip_erase = 1'b0;
    sect_erase = 1'b0;
    abort      = fire && (cmd == CB_ABORT) && (mode != M_PROG);
    if (abort) begin
      nxt  = M_READ;
      nbyp = 1'b0;
    end else if (fire) begin
      case (mode)
        M_READ, M_EUNLK1: begin
          if (at_query && cmd == CB_QUERY) begin
            nxt = M_CFI;
          end else if (at_a && cmd == CB_KEY1) begin
            nxt = (mode == M_READ) ? M_UNLK2 : M_EUNLK2;
          end else begin
            nxt  = M_READ;
            nbyp = 1'b0;
          end
        end
        M_UNLK2, M_EUNLK2: begin
          if (at_b && cmd == CB_KEY2) begin
            nxt = (mode == M_UNLK2) ? M_CMD : M_ESEL;
          end else begin
            nxt  = M_READ;
            nbyp = 1'b0;
          end
        end
        M_CMD: begin
          if (!bypass && !at_a) begin
            nxt  = M_READ;
            nbyp = 1'b0;
          end else begin
            case (cmd)
              CB_BYPASS:  begin nbyp = 1'b1; nxt = M_CMD; end
              CB_ESETUP:  nxt = M_EUNLK1;
              CB_AUTOSEL: nxt = M_AUTO;
              CB_PROG:    nxt = M_PROG;
              default: begin
                nxt  = M_READ;
                nbyp = 1'b0;
              end
            endcase
          end
        end
        M_PROG: begin
          prog_en = 1'b1;
          nxt     = bypass ? M_CMD : M_READ;
        end
        M_ESEL: begin
          if (cmd == CB_CHIP && at_a) begin
            chip_erase = 1'b1;
            nxt        = M_ERASE;
          end else if (cmd == CB_SECT) begin
            sect_erase = 1'b1;
            nxt        = M_ERASE;
          end else begin
            nxt  = M_READ;
            nbyp = 1'b0;
          end
        end
        M_ERASE: begin
          nxt = M_ERASE;
        end
        M_AUTO: begin
          if (bypass && cmd == CB_BYPEXIT) begin
            nxt  = M_READ;
            nbyp = 1'b0;
          end else if (at_query && cmd == CB_QUERY) begin
            nxt = M_CFI;
          end else begin
            nxt  = M_READ;
            nbyp = 1'b0;
          end
        end
        default: begin
          nxt  = M_READ;
          nbyp = 1'b0;
        end
      endcase
    end
    if (mode == M_ERASE && erase_done && !abort) begin
      nxt = bypass ? M_CMD : M_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode        <= M_READ;
      bypass      <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      mode        <= nxt;
      bypass      <= nbyp;
      erase_start <= chip_erase | sect_erase;
    end
  end

  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd == CB_ABORT && mode != M_PROG) |=> (mode == M_READ && !bypass));

  p_key1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_READ && fire && at_a && cmd == CB_KEY1) |=> (mode == M_UNLK2));

  p_key2_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UNLK2 && fire && !(at_b && cmd == CB_KEY2)) |=> (mode == M_READ));

  p_bypass_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass) |-> (mode == M_CMD));

  p_prog_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG && fire) |=> (mode == ($past(bypass) ? M_CMD : M_READ)));

  p_erase_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (mode == M_ERASE || $past(erase_done) || $past(fire)));

  p_erase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && !erase_done && !(fire && cmd == CB_ABORT)) |=> (mode == M_ERASE));

  p_auto_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_AUTO && fire) |=> (mode == M_READ || mode == M_CFI));

  p_query_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CFI && fire) |=> (mode == M_READ));

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int SECT_BYTES = 256,
  parameter int SECT_NUM   = 4,
  parameter bit BIG_END    = 1'b0,
  parameter int AW         = 10,
  parameter int SW         = 8,
  parameter int SIW        = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ro,
  input  logic           prog_en,
  input  logic           chip_erase,
  input  logic           sect_erase,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [2:0]     nbytes,
  input  logic [SIW-1:0] sect_idx,
  input  logic [AW-1:0]  rd_addr,
  output logic [31:0]    rd_data
);

  localparam int NB    = SECT_BYTES * SECT_NUM;
  localparam int LANES = 4;

  logic [7:0] mem     [NB];
  logic [7:0] mem_nxt [NB];
  logic [LANES-1:0][AW-1:0] lane_addr;
  logic [LANES-1:0][7:0]    lane_val;
  logic [LANES-1:0]         lane_en;
  logic [31:0]              rd_nxt;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_addr[k] = wr_addr + AW'(k);
      assign lane_en[k]   = (3'(k) < nbytes);
      if (BIG_END) begin : g_be
        logic [31:0] shv;
        assign shv         = lane_en[k] ? (wr_data >> (8 * (int'(nbytes) - 1 - k))) : 32'hFFFF_FFFF;
        assign lane_val[k] = shv[7:0];
      end else begin : g_le
        assign lane_val[k] = wr_data[8*k +: 8];
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      mem_nxt[i] = mem[i];
      if (!ro) begin
        if (chip_erase || (sect_erase && SIW'(i >> SW) == sect_idx)) begin
          mem_nxt[i] = 8'hFF;
        end else if (prog_en) begin
          for (int k = 0; k < LANES; k++) begin
            if (lane_en[k] && lane_addr[k] == AW'(i)) begin
              mem_nxt[i] = mem_nxt[i] & lane_val[k];
            end
          end
        end
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    for (int k = 0; k < LANES; k++) begin
      if (BIG_END) rd_nxt[8*(LANES-1-k) +: 8] = mem[rd_addr + AW'(k)];
      else         rd_nxt[8*k +: 8]           = mem[rd_addr + AW'(k)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
      rd_data <= '0;
    end else begin
      for (int i = 0; i < NB; i++) mem[i] <= mem_nxt[i];
      rd_data <= rd_nxt;
    end
  end

  p_ro_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ro |=> (mem[0] == $past(mem[0]) && mem[NB-1] == $past(mem[NB-1])));

  p_chip_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase && !ro) |=> (mem[0] == 8'hFF && mem[NB-1] == 8'hFF));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int SECT_BYTES = 256,
  parameter int SECT_NUM   = 4,
  parameter int DEV_W      = 1,
  parameter bit BIG_END    = 1'b0,
  parameter int UNLK_A     = 'hAA,
  parameter int UNLK_B     = 'h55
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_valid,
  output logic                                    wr_ready,
  input  logic [$clog2(SECT_BYTES*SECT_NUM)-1:0]  wr_addr,
  input  logic [31:0]                             wr_data,
  input  logic [1:0]                              wr_size,
  input  logic                                    ro_i,
  input  logic                                    erase_done_i,
  input  logic [$clog2(SECT_BYTES*SECT_NUM)-1:0]  rd_addr,
  output logic [31:0]                             rd_data,
  output logic [3:0]                              mode_o,
  output logic                                    bypass_o,
  output logic                                    erase_start_o
);

  localparam int AW  = $clog2(SECT_BYTES * SECT_NUM);
  localparam int SW  = $clog2(SECT_BYTES);
  localparam int SIW = (SECT_NUM > 1) ? $clog2(SECT_NUM) : 1;
  localparam logic [SW-1:0] OFF_A = SW'(UNLK_A);
  localparam logic [SW-1:0] OFF_B = SW'(UNLK_B);
  localparam logic [SW-1:0] OFF_Q = SW'(QUERY_OFF);

  logic [SW-1:0]  word_off;
  logic [SIW-1:0] sect_idx;
  logic           fire;
  fmode_t         mode;
  logic           prog_en, chip_erase, sect_erase;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid & wr_ready;
  assign mode_o   = mode;

  flash_addr_split #(
    .SECT_NUM (SECT_NUM),
    .DEV_W    (DEV_W),
    .AW       (AW),
    .SW       (SW),
    .SIW      (SIW)
  ) u_split (
    .addr     (wr_addr),
    .word_off (word_off),
    .sect_idx (sect_idx)
  );

  flash_cmd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .cmd         (wr_data[7:0]),
    .at_a        (word_off == OFF_A),
    .at_b        (word_off == OFF_B),
    .at_query    (word_off == OFF_Q),
    .erase_done  (erase_done_i),
    .mode        (mode),
    .bypass      (bypass_o),
    .prog_en     (prog_en),
    .chip_erase  (chip_erase),
    .sect_erase  (sect_erase),
    .erase_start (erase_start_o)
  );

  flash_byte_array #(
    .SECT_BYTES (SECT_BYTES),
    .SECT_NUM   (SECT_NUM),
    .BIG_END    (BIG_END),
    .AW         (AW),
    .SW         (SW),
    .SIW        (SIW)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .ro         (ro_i),
    .prog_en    (prog_en),
    .chip_erase (chip_erase),
    .sect_erase (sect_erase),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .nbytes     (size_to_bytes(wr_size)),
    .sect_idx   (sect_idx),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int SB = 256;
  localparam int SN = 4;
  localparam int N  = SB * SN;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ready, ro_i, erase_done_i, bypass_o, erase_start_o;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  wr_size;
  logic [3:0]  mode_o;

  always #4 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size), .ro_i(ro_i),
    .erase_done_i(erase_done_i), .rd_addr(rd_addr), .rd_data(rd_data),
    .mode_o(mode_o), .bypass_o(bypass_o), .erase_start_o(erase_start_o)
  );

  int         m_mode;
  bit         m_byp;
  logic [7:0] m [N];
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done_run = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int a, input logic [31:0] d, input int sz,
                     input bit done, input bit ro, input int ra, input string tag);
    int nm; bit nbyp; bit est; int off; int nb; logic [7:0] c; logic [31:0] erd;
    for (int k = 0; k < 4; k++) erd[8*k +: 8] = m[(ra + k) % N];
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    c = d[7:0]; off = a % SB; nm = m_mode; nbyp = m_byp; est = 0;
    if (v) begin
      if (c == 8'hF0 && m_mode != 3) begin nm = 0; nbyp = 0; end
      else begin
        case (m_mode)
          0: if (off == 'h55 && c == 8'h98) nm = 9;
             else if (off == 'hAA && c == 8'hAA) nm = 1;
             else begin nm = 0; nbyp = 0; end
          1: if (off == 'h55 && c == 8'h55) nm = 2; else begin nm = 0; nbyp = 0; end
          2: if (!m_byp && off != 'hAA) begin nm = 0; nbyp = 0; end
             else if (c == 8'h20) begin nbyp = 1; nm = 2; end
             else if (c == 8'h80) nm = 4;
             else if (c == 8'h90) nm = 8;
             else if (c == 8'hA0) nm = 3;
             else begin nm = 0; nbyp = 0; end
          3: begin
               if (!ro) for (int k = 0; k < nb; k++) m[(a + k) % N] &= d[8*k +: 8];
               nm = m_byp ? 2 : 0;
             end
          4: if (off == 'h55 && c == 8'h98) nm = 9;
             else if (off == 'hAA && c == 8'hAA) nm = 5;
             else begin nm = 0; nbyp = 0; end
          5: if (off == 'h55 && c == 8'h55) nm = 6; else begin nm = 0; nbyp = 0; end
          6: if (c == 8'h10 && off == 'hAA) begin
               if (!ro) for (int i = 0; i < N; i++) m[i] = 8'hFF;
               nm = 7; est = 1;
             end else if (c == 8'h30) begin
               if (!ro) for (int i = 0; i < SB; i++) m[(a / SB) * SB + i] = 8'hFF;
               nm = 7; est = 1;
             end else begin nm = 0; nbyp = 0; end
          7: ;
          8: if (m_byp && c == 8'h00) begin nm = 0; nbyp = 0; end
             else if (off == 'h55 && c == 8'h98) nm = 9;
             else begin nm = 0; nbyp = 0; end
          default: begin nm = 0; nbyp = 0; end
        endcase
      end
    end
    if (m_mode == 7 && done && !(v && c == 8'hF0)) nm = m_byp ? 2 : 0;
    wr_valid = v; wr_addr = AW'(a); wr_data = d; wr_size = 2'(sz);
    erase_done_i = done; ro_i = ro; rd_addr = AW'(ra);
    @(posedge clk);
    m_mode = nm; m_byp = nbyp;
    @(negedge clk);
    check(mode_o == 4'(m_mode), tag, "mode", {28'd0, mode_o}, 32'(m_mode));
    check(bypass_o == m_byp, tag, "bypass", {31'd0, bypass_o}, {31'd0, m_byp});
    check(erase_start_o == est, tag, "erase_start", {31'd0, erase_start_o}, {31'd0, est});
    check(rd_data == erd, tag, "rd_data", rd_data, erd);
  endtask

  task automatic w(input int a, input logic [7:0] d, input string tag);
    cyc(1, a, {24'd0, d}, 0, 0, 0, a, tag);
  endtask

  task automatic key(input string tag);
    w('hAA, 8'hAA, tag);
    w('h55, 8'h55, tag);
  endtask

  task automatic rdc(input int ra, input string tag);
    cyc(0, 0, 0, 0, 0, 0, ra, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] cmds [12] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'h20,
                              8'h98, 8'h10, 8'h30, 8'hF0, 8'h00, 8'h3C};
    rst_n = 0; wr_valid = 0; wr_addr = 0; wr_data = 0; wr_size = 0;
    ro_i = 0; erase_done_i = 0; rd_addr = 0;
    m_mode = 0; m_byp = 0;
    for (int i = 0; i < N; i++) m[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(mode_o == 4'd0, "R1", "mode", {28'd0, mode_o}, 0);
    check(!bypass_o && !erase_start_o, "R1", "flags", {30'd0, bypass_o, erase_start_o}, 0);
    check(rd_data == 32'd0, "R1", "rd_data", rd_data, 0);
    check(wr_ready == 1'b1, "R1", "wr_ready", {31'd0, wr_ready}, 1);
    rdc(0, "R1"); rdc(N - 4, "R12");
    // R6 byte program, then AND with 0xF0 as data (R2 exception)
    key("R4"); w('hAA, 8'hA0, "R5"); w('h10, 8'h5A, "R6");
    key("R4"); w('hAA, 8'hA0, "R5"); w('h10, 8'hF0, "R2");
    rdc('h10, "R6");
    // R6 halfword and word, word spanning a sector edge
    key("R6"); w('hAA, 8'hA0, "R6"); cyc(1, 'h20, 32'h0000_1234, 1, 0, 0, 'h20, "R6");
    key("R6"); w('hAA, 8'hA0, "R6"); cyc(1, 'hFE, 32'h8765_4321, 2, 0, 0, 'hFE, "R6");
    rdc('h20, "R12"); rdc('hFE, "R12");
    // R3 and R4 broken handshakes
    w('h00, 8'hAA, "R3"); w('hAA, 8'hAA, "R3"); w('h54, 8'h55, "R4");
    w('hAA, 8'hAA, "R4"); w('h55, 8'h54, "R4");
    // R5 wrong offset and unknown command
    key("R5"); w('h10, 8'hA0, "R5");
    key("R5"); w('hAA, 8'h77, "R5");
    // R5 bypass entry; program at any address; autoselect exit
    key("R5"); w('hAA, 8'h20, "R5");
    w('h33, 8'hA0, "R5"); w('h33, 8'h0F, "R6");
    w('h01, 8'h90, "R10"); w('h01, 8'h00, "R10");
    // R2 abort clears bypass
    key("R2"); w('hAA, 8'h20, "R2"); w('h00, 8'hF0, "R2");
    // R10 autoselect to query, R11 leave query
    key("R10"); w('hAA, 8'h90, "R10"); w('h55, 8'h98, "R10"); w('h00, 8'h00, "R11");
    w('h55, 8'h98, "R3"); w('h12, 8'h34, "R11");
    // R7 query from erase setup, and broken second pair
    key("R7"); w('hAA, 8'h80, "R7"); w('h55, 8'h98, "R7"); w('h00, 8'h00, "R11");
    key("R7"); w('hAA, 8'h80, "R7"); w('hAA, 8'hAA, "R7"); w('h56, 8'h55, "R7");
    // R8 sector erase of sector 0 with ignored writes, then done
    key("R8"); w('hAA, 8'h80, "R8"); key("R8"); w('h05, 8'h30, "R8");
    w('hAA, 8'hAA, "R9"); w('h10, 8'h00, "R9"); rdc('h10, "R9");
    cyc(0, 0, 0, 0, 1, 0, 'h20, "R9"); rdc('hFE, "R8");
    // R8 chip erase at wrong offset resets; then chip erase; abort during erase
    key("R8"); w('hAA, 8'h80, "R8"); key("R8"); w('h11, 8'h10, "R8");
    key("R8"); w('hAA, 8'h80, "R8"); key("R8"); w('hAA, 8'h10, "R8");
    w('h00, 8'hF0, "R9"); rdc('h100, "R8");
    // R6 and R8 with read-only: modes advance, array holds
    key("R6"); w('hAA, 8'hA0, "R6"); cyc(1, 'h40, 32'h0, 0, 0, 1, 'h40, "R6");
    key("R8"); w('hAA, 8'h80, "R8"); key("R8"); w('hAA, 8'h10, "R8");
    cyc(0, 0, 0, 0, 1, 0, 'h40, "R9");
    key("R8"); w('hAA, 8'hA0, "R6"); w('h40, 8'h00, "R6");
    key("R8"); w('hAA, 8'h80, "R8"); key("R8"); cyc(1, 'hAA, 32'h10, 0, 0, 1, 'h40, "R8");
    cyc(0, 0, 0, 0, 1, 0, 'h40, "R9");
    // R9 erase end in bypass returns to command ready
    key("R9"); w('hAA, 8'h20, "R9"); w('h00, 8'h80, "R9"); key("R9");
    w('h205, 8'h30, "R9"); cyc(1, 'h10, 32'h55, 0, 1, 0, 'h200, "R9");
    w('h00, 8'hF0, "R2");
    // biased random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int sel; int a; logic [31:0] d;
      sel = $urandom % 4;
      a = (sel == 0) ? 'hAA : (sel == 1) ? 'h55 : (sel == 2) ? 'h155 : int'($urandom % N);
      d = $urandom;
      d[7:0] = cmds[$urandom % 12];
      cyc(($urandom % 5) != 0, a, d, $urandom % 3, ($urandom % 6) == 0,
          ($urandom % 16) == 0, $urandom % N, "R2");
    end
    done_run = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule